// File: doc/BRIEF.md
# Target Status and Interrupt Register

This block holds the status view and the interrupt logic of a serial-bus target. A bus monitor, outside this block, delivers single-cycle pulses when it sees a start condition, a stop condition or a match of this target's address. The receive and transmit FIFOs, also outside, deliver two levels: receive data waiting and transmit space free. The block turns these inputs into event bits that stay set until software clears them, live bits that follow the bus and FIFO state, and one interrupt line.

Software reaches the block through a plain word-addressed port. A single `addr` selects the register for both reads and writes, and reads are combinational. The configuration register holds one option. When set, start and stop events are recorded only after the target has seen its own address. Software can then wait for the stop that closes a message addressed to this target and ignore traffic meant for other targets. The receive-pending bit is not cleared by software. It drops on its own once the receive FIFO has been read empty.

Top module: `tgt_stat_irq`

## Requirements
- R1: After a synchronous reset, every register reads zero: the configuration, the status, the enables and the masked view. `irq` is low.
- R2: A pulse on `ev_match` sets MATCHED (status bit 9) at the next clock edge. The bit stays set until software clears it.
- R3: With gating off, `ev_start` sets START (status bit 8) and `ev_stop` sets STOP (status bit 10) at the next clock edge. Both bits are sticky.
- R4: Configuration bit 0 (address 0) is the gating option. When it is 1, a start or stop event sets its sticky bit only if MATCHED was already set before that event's clock edge.
- R5: Status bit 0 is the live bus-busy bit. It goes to 1 on a start and to 0 on a stop. A start and a stop in the same cycle leave the bus busy and do not set STOP, so a quick stop-then-start does not raise the stop event.
- R6: Writing 1 to status bits 8 to 10 (address 1) clears those sticky bits. If a set event and a clearing write fall in the same cycle, the bit ends up set.
- R7: Status bit 11 (receive pending) and status bit 12 (transmit not full) follow `rx_nonempty` and `tx_notfull` one cycle later. Receive pending drops by itself when the FIFO drains. Writes to bits 11, 12 and 0 have no effect.
- R8: Writing 1s to address 2 sets interrupt-enable bits. Writing 1s to address 3 clears them. Both addresses read back the enables at bits 8 to 12, with all other bits zero. Addresses 5 to 7 read zero.
- R9: Address 4 reads the status bits 8 to 12 ANDed with the enables. `irq` is high exactly when any of these masked bits is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_start | input | 1 | Start condition seen (pulse) |
| ev_stop | input | 1 | Stop condition seen (pulse) |
| ev_match | input | 1 | Own address matched (pulse) |
| rx_nonempty | input | 1 | Receive FIFO holds data (level) |
| tx_notfull | input | 1 | Transmit FIFO has space (level) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The directed part walks through one addressed message with gating off and the same message with gating on. Comparing the two separates the plain sticky set from the match-qualified set. A start and a stop in the same cycle show whether the busy bit and the STOP event treat that case as a restart. A clearing write in the same cycle as a match event shows which of the two wins. Writes to the live bits and a draining receive FIFO show that bits 11 and 12 depend only on the FIFO inputs. A long stretch of random pulses, FIFO levels and writes to every address is then compared against a reference model on each cycle. This catches ordering faults between enables, masking and the interrupt.

// File: rtl/tgt_stat_pkg.sv
package tgt_stat_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    // status bit positions seen by software
    localparam int BIT_BUSY  = 0;
    localparam int BIT_START = 8;
    localparam int BIT_MATCH = 9;
    localparam int BIT_STOP  = 10;
    localparam int BIT_RXP   = 11;
    localparam int BIT_TXNF  = 12;

    // interrupt-capable field
    localparam int IRQ_LSB = BIT_START;
    localparam int IRQ_W   = BIT_TXNF - BIT_START + 1;

    // sticky bank indices
    localparam int N_STICKY = 3;
    localparam int S_START  = BIT_START - IRQ_LSB;
    localparam int S_MATCH  = BIT_MATCH - IRQ_LSB;
    localparam int S_STOP   = BIT_STOP  - IRQ_LSB;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG    = 3'd0,
        A_STAT   = 3'd1,
        A_ENSET  = 3'd2,
        A_ENCLR  = 3'd3,
        A_MASKED = 3'd4
    } reg_addr_e;

    // LSB first: start, match, stop, rx pending, tx not full
    typedef struct packed {
        logic txnf;
        logic rxp;
        logic stop;
        logic match;
        logic start;
    } irq_vec_t;

    function automatic logic [REG_W-1:0] place_field(logic [IRQ_W-1:0] f);
        logic [REG_W-1:0] r;
        r = '0;
        r[IRQ_LSB +: IRQ_W] = f;
        return r;
    endfunction

endpackage

// File: rtl/tgt_bus_track.sv
module tgt_bus_track
    import tgt_stat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ev_start,
    input  logic                ev_stop,
    input  logic                ev_match,
    input  logic                gate,
    input  logic                matched_q,
    output logic                busy,
    output logic [N_STICKY-1:0] set_vec
);

    logic qual;

    always_comb begin
        qual             = !gate || matched_q;
        set_vec          = '0;
        set_vec[S_START] = ev_start && qual;
        set_vec[S_MATCH] = ev_match;
        // a stop coinciding with a start is a restart: no stopped state
        set_vec[S_STOP]  = ev_stop && !ev_start && qual;
    end

    always_ff @(posedge clk) begin
        if (rst)           busy <= 1'b0;
        else if (ev_start) busy <= 1'b1;
        else if (ev_stop)  busy <= 1'b0;
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> busy); // R5
    AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        (ev_stop && !ev_start) |=> !busy); // R5

endmodule

// File: rtl/tgt_sticky_bank.sv
module tgt_sticky_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic r_q;

        always_ff @(posedge clk) begin
            if (rst)         r_q <= 1'b0;
            else if (set[g]) r_q <= 1'b1;
            else if (clr[g]) r_q <= 1'b0;
        end

        assign q[g] = r_q;

        AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
            set[g] |=> q[g]); // R6
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            (q[g] && !clr[g]) |=> q[g]); // R2
    end

endmodule

// File: rtl/tgt_int_enable.sv
module tgt_int_enable #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] status,
    output logic [W-1:0] en,
    output logic [W-1:0] masked,
    output logic         irq
);

    always_ff @(posedge clk) begin
        if (rst)         en <= '0;
        else if (set_wr) en <= en | wdata;
        else if (clr_wr) en <= en & ~wdata;
    end

    assign masked = status & en;
    assign irq    = |masked;

    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        set_wr |=> ((en & $past(wdata)) == $past(wdata))); // R8
    AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !set_wr) |=> ((en & $past(wdata)) == '0)); // R8
    AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq); // R9

endmodule

// File: rtl/tgt_stat_irq.sv
module tgt_stat_irq
    import tgt_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_match,
    input  logic              rx_nonempty,
    input  logic              tx_notfull,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq
);

    logic                cfg_gate;
    logic                busy;
    logic                rx_q;
    logic                tx_q;
    logic [N_STICKY-1:0] st_set;
    logic [N_STICKY-1:0] st_clr;
    logic [N_STICKY-1:0] st_q;
    irq_vec_t            stat_vec;
    logic [IRQ_W-1:0]    en;
    logic [IRQ_W-1:0]    masked;
    logic                wr_cfg, wr_stat, wr_enset, wr_enclr;
    logic                unused_wd;

    assign wr_cfg   = wr_en && (addr == A_CFG);
    assign wr_stat  = wr_en && (addr == A_STAT);
    assign wr_enset = wr_en && (addr == A_ENSET);
    assign wr_enclr = wr_en && (addr == A_ENCLR);
    assign unused_wd = ^{wr_data[REG_W-1:BIT_TXNF+1], wr_data[IRQ_LSB-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_gate <= 1'b0;
            rx_q     <= 1'b0;
            tx_q     <= 1'b0;
        end else begin
            if (wr_cfg) cfg_gate <= wr_data[0];
            rx_q <= rx_nonempty;
            tx_q <= tx_notfull;
        end
    end

    tgt_bus_track u_track (
        .clk       (clk),
        .rst       (rst),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .ev_match  (ev_match),
        .gate      (cfg_gate),
        .matched_q (st_q[S_MATCH]),
        .busy      (busy),
        .set_vec   (st_set)
    );

    assign st_clr = wr_stat ? wr_data[IRQ_LSB +: N_STICKY] : '0;

    tgt_sticky_bank #(.N(N_STICKY)) u_sticky (
        .clk (clk),
        .rst (rst),
        .set (st_set),
        .clr (st_clr),
        .q   (st_q)
    );

    always_comb begin
        stat_vec.start = st_q[S_START];
        stat_vec.match = st_q[S_MATCH];
        stat_vec.stop  = st_q[S_STOP];
        stat_vec.rxp   = rx_q;
        stat_vec.txnf  = tx_q;
    end

    tgt_int_enable #(.W(IRQ_W)) u_inten (
        .clk    (clk),
        .rst    (rst),
        .set_wr (wr_enset),
        .clr_wr (wr_enclr),
        .wdata  (wr_data[IRQ_LSB +: IRQ_W]),
        .status (stat_vec),
        .en     (en),
        .masked (masked),
        .irq    (irq)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            A_CFG:    rd_data[0] = cfg_gate;
            A_STAT: begin
                rd_data           = place_field(stat_vec);
                rd_data[BIT_BUSY] = busy;
            end
            A_ENSET,
            A_ENCLR:  rd_data = place_field(en);
            A_MASKED: rd_data = place_field(masked);
            default:  rd_data = '0;
        endcase
    end

    AST_GATED_START: assert property (@(posedge clk) disable iff (rst)
        (cfg_gate && !st_q[S_MATCH] && !st_q[S_START]) |=> !st_q[S_START]); // R4
    AST_GATED_STOP: assert property (@(posedge clk) disable iff (rst)
        (cfg_gate && !st_q[S_MATCH] && !st_q[S_STOP]) |=> !st_q[S_STOP]); // R4
    AST_RX_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !rx_nonempty |=> !rx_q); // R7
    AST_TX_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        tx_notfull |=> tx_q); // R7

endmodule

// File: tb/tb_tgt_stat_irq.sv
`timescale 1ns/1ps
module tb_tgt_stat_irq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_start = 0, ev_stop = 0, ev_match = 0;
    logic        rx_nonempty = 0, tx_notfull = 0;
    logic        wr_en = 0;
    logic [2:0]  addr = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    bit m_busy, m_start, m_match, m_stop, m_rxp, m_txn, m_gate;
    bit [4:0] m_en;

    always #2 clk = ~clk;

    tgt_stat_irq dut (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_match(ev_match), .rx_nonempty(rx_nonempty), .tx_notfull(tx_notfull),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic bit [4:0] m_field();
        return {m_txn, m_rxp, m_stop, m_match, m_start};
    endfunction

    function automatic bit [31:0] m_read(bit [2:0] a);
        bit [31:0] r = '0;
        case (a)
            3'd0: r[0] = m_gate;
            3'd1: begin r[12:8] = m_field(); r[0] = m_busy; end
            3'd2, 3'd3: r[12:8] = m_en;
            3'd4: r[12:8] = m_field() & m_en;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_update();
        bit q, ns, np, nm;
        bit [31:0] clr;
        if (rst) begin
            {m_busy, m_start, m_match, m_stop, m_rxp, m_txn, m_gate} = '0;
            m_en = '0;
            return;
        end
        q   = !m_gate || m_match;
        ns  = ev_start && q;
        np  = ev_stop && !ev_start && q;
        nm  = ev_match;
        clr = (wr_en && addr == 3'd1) ? wr_data : 32'h0;
        m_start = ns || (m_start && !clr[8]);
        m_match = nm || (m_match && !clr[9]);
        m_stop  = np || (m_stop  && !clr[10]);
        if (ev_start) m_busy = 1; else if (ev_stop) m_busy = 0;
        m_rxp = rx_nonempty;
        m_txn = tx_notfull;
        if (wr_en && addr == 3'd0) m_gate = wr_data[0];
        if (wr_en && addr == 3'd2) m_en = m_en | wr_data[12:8];
        if (wr_en && addr == 3'd3) m_en = m_en & ~wr_data[12:8];
    endtask

    task automatic check(string tag, bit [31:0] got, bit [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string addr_tag(bit [2:0] a);
        case (a)
            3'd0: return "R4";
            3'd1: return "R2";
            3'd4: return "R9";
            default: return "R8";
        endcase
    endfunction

    // one clock: model follows the edge, compare at the falling edge
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(addr_tag(addr), rd_data, m_read(addr));
        check("R9", {31'h0, irq}, {31'h0, |(m_field() & m_en)});
        ev_start = 0; ev_stop = 0; ev_match = 0; wr_en = 0;
    endtask

    task automatic wr(bit [2:0] a, bit [31:0] d);
        addr = a; wr_data = d; wr_en = 1; step();
    endtask

    task automatic peek(bit [2:0] a, output bit [31:0] v);
        addr = a; #1; v = rd_data;
    endtask

    initial begin : main
        bit [31:0] v;
        @(negedge clk);
        step(); step();
        rst = 0;
        step();
        // R1 reset state
        peek(3'd1, v); check("R1", v, 32'h0);
        peek(3'd2, v); check("R1", v, 32'h0);
        peek(3'd0, v); check("R1", v, 32'h0);
        check("R1", {31'h0, irq}, 32'h0);

        // R3 start, R5 busy
        addr = 3'd1; ev_start = 1; step();
        peek(3'd1, v); check("R3", v, 32'h0000_0101);
        ev_match = 1; step();
        peek(3'd1, v); check("R2", v, 32'h0000_0301);
        ev_stop = 1; step();
        peek(3'd1, v); check("R3", v, 32'h0000_0700);
        // R6 write-one-to-clear
        wr(3'd1, 32'h0000_0100);
        peek(3'd1, v); check("R6", v, 32'h0000_0600);
        // R6 set wins over clear
        addr = 3'd1; wr_data = 32'h0000_0200; wr_en = 1; ev_match = 1; step();
        peek(3'd1, v); check("R6", v, 32'h0000_0600);
        wr(3'd1, 32'h0000_0700);
        peek(3'd1, v); check("R6", v, 32'h0);

        // R4 gating on
        wr(3'd0, 32'h1);
        peek(3'd0, v); check("R4", v, 32'h1);
        addr = 3'd1; ev_start = 1; step();
        peek(3'd1, v); check("R4", v, 32'h0000_0001);
        ev_match = 1; step();
        peek(3'd1, v); check("R4", v, 32'h0000_0201);
        ev_stop = 1; step();
        peek(3'd1, v); check("R4", v, 32'h0000_0600);

        // R5 restart: start and stop together
        wr(3'd1, 32'h0000_0700);
        wr(3'd0, 32'h0);
        addr = 3'd1; ev_start = 1; ev_stop = 1; step();
        peek(3'd1, v); check("R5", v, 32'h0000_0101);

        // R7 live bits
        rx_nonempty = 1; tx_notfull = 1; step();
        peek(3'd1, v); check("R7", v, 32'h0000_1901);
        wr(3'd1, 32'h0000_1801);
        peek(3'd1, v); check("R7", v, 32'h0000_1901);
        rx_nonempty = 0; step();
        peek(3'd1, v); check("R7", v, 32'h0000_1101);

        // R8 enables
        wr(3'd2, 32'hFFFF_FFFF);
        peek(3'd2, v); check("R8", v, 32'h0000_1F00);
        wr(3'd3, 32'h0000_0500);
        peek(3'd3, v); check("R8", v, 32'h0000_1A00);
        peek(3'd6, v); check("R8", v, 32'h0);

        // R9 masked view and interrupt
        peek(3'd4, v); check("R9", v, 32'h0000_1000);
        check("R9", {31'h0, irq}, 32'h1);
        wr(3'd3, 32'h0000_1F00);
        check("R9", {31'h0, irq}, 32'h0);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom;
            ev_start    = (r[2:0] == 0);
            ev_stop     = (r[5:3] == 0);
            ev_match    = (r[8:6] == 0);
            rx_nonempty = r[9] ^ r[10];
            tx_notfull  = r[11] | r[12];
            addr        = r[15:13];
            wr_en       = (r[18:16] == 0);
            wr_data     = $urandom;
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule